// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, weekday, month and a two-digit year as BCD values. Each pulse on a one-second tick input advances the seconds. Each field wraps at its own limit and carries into the next field in the same clock cycle. The day of month wraps at the length of the current month, and February follows a leap-year rule for the years 00 to 99.

Software uses a byte-wide register port. A write is accepted on the clock edge. A read is a combinational decode of the address. The block has these controls and status:
- a control register that selects the 12-hour or 24-hour hour format;
- a stop bit in that control register, which freezes the time;
- a sticky integrity flag in the seconds byte, which shows that the time may be wrong after the oscillator failed.

The register port is a plain control path. It has no handshake, and every write completes in one cycle. Changing the hour format does not convert the stored hour. Software writes the hour again in the new format.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, the day of month is 01, the weekday is 0, the month is 01 and the year is 00. The control register reads 0x00. The integrity flag is set, so the seconds byte reads 0x80.
- R2: Address 0x00 is the control register. Bit 3 selects 12-hour mode and bit 5 is stop. The time registers sit at addresses 0x03 to 0x09 in this order: seconds, minutes, hours, date, weekday, month, year. The unused high bits of each register read 0. Any other address reads 0x00, and writes to it are ignored.
- R3: The seconds and the minutes each count 00 to 59 in BCD. At 59 a field wraps to 00 and carries into the next field.
- R4: In 24-hour mode the hour counts 00 to 23 in BCD. The step from 23 to 00 advances the day.
- R5: In 12-hour mode the hour sits in bits [4:0] as BCD 01 to 12, and bit 5 is PM. The sequence is 11 to 12 with PM toggled, then 12 to 01 with PM kept. The step from 11 PM to 12 AM advances the day.
- R6: The date wraps to 01 after the last day of the month:
  - 31 days in months 01, 03, 05, 07, 08, 10 and 12;
  - 30 days in months 04, 06, 09 and 11;
  - 29 days in February of a leap year, and 28 days otherwise. A leap year is a year whose value is divisible by 4.
- R7: The weekday counts 0 to 6. It steps once on each day rollover and wraps from 6 to 0.
- R8: The month counts 01 to 12. A date wrap in month 12 sets the month to 01 and advances the year. The year wraps from 99 to 00.
- R9: While stop is 1, ticks change no time field. When stop returns to 0, counting resumes.
- R10: The integrity flag is bit 7 of the seconds byte. An osc_fail pulse sets it. A seconds write loads it from write bit 7, so writing 0 clears it. The flag does not affect counting.
- R11: A write to any time register in the same cycle as a tick takes the written value. That tick is then discarded for all fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| osc_fail | input | 1 | Oscillator failure indication; sets the integrity flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |

## Verification
The range assertions take for granted that every value software writes into a time register is valid BCD within that field's limits. This covers a date that fits the month, a 12-hour value from 01 to 12 when 12-hour mode is selected, and a nonzero month. The directed stimulus only ever writes such values. It switches the hour format only together with rewriting the hour in the new format. Ticks are single-cycle pulses spaced by at least one idle cycle, which matches how the carry assertions are written.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int RTC_A_CTRL = 0;
  localparam int RTC_A_SEC  = 3;
  localparam int RTC_A_MIN  = 4;
  localparam int RTC_A_HOUR = 5;
  localparam int RTC_A_DATE = 6;
  localparam int RTC_A_WDAY = 7;
  localparam int RTC_A_MON  = 8;
  localparam int RTC_A_YEAR = 9;

  localparam int CTRL_BIT_MODE12 = 3;
  localparam int CTRL_BIT_STOP   = 5;

  // Advance a two-digit BCD byte by one (no range wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    logic [7:0] r;
    if (x[3:0] == 4'h9) r = {x[7:4] + 4'h1, 4'h0};
    else                r = {x[7:4], x[3:0] + 4'h1};
    return r;
  endfunction

  // Leap rule for a BCD year 00..99: value divisible by 4.
  function automatic logic is_leap(input logic [7:0] yr);
    int v;
    v = int'(yr[7:4]) * 10 + int'(yr[3:0]);
    return (v % 4) == 0;
  endfunction

  // Last day of the month, returned in BCD.
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter int         W  = 7,
  parameter logic [7:0] LO = 8'h00,
  parameter logic [7:0] HI = 8'h59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);

  logic [7:0] ext_q;
  logic [7:0] ext_next;
  logic       at_top;

  assign ext_q    = 8'(value);
  assign at_top   = (ext_q == HI);
  assign ext_next = at_top ? LO : bcd_inc(ext_q);
  assign carry    = inc && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= LO[W-1:0];
    else if (wr_en)  value <= wr_val;
    else if (inc)    value <= ext_next[W-1:0];
  end

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (8'(value) >= LO) && (8'(value) <= HI));

  a_r3_wrap_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !wr_en) |=> (8'(value) == LO));

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode12,
  input  logic       wr_en,
  input  logic [5:0] wr_val,
  input  logic       inc,
  output logic [5:0] value,
  output logic       carry
);

  logic [5:0] nxt;
  logic       wrap;
  logic [7:0] inc12;
  logic [7:0] inc24;

  assign inc12 = bcd_inc({3'b000, value[4:0]});
  assign inc24 = bcd_inc({2'b00, value});

  always_comb begin
    nxt  = value;
    wrap = 1'b0;
    if (mode12) begin
      if (value[4:0] == 5'h12) begin
        nxt = {value[5], 5'h01};
      end else if (value[4:0] == 5'h11) begin
        nxt  = {~value[5], 5'h12};
        wrap = value[5];
      end else begin
        nxt = {value[5], inc12[4:0]};
      end
    end else begin
      if (value == 6'h23) begin
        nxt  = 6'h00;
        wrap = 1'b1;
      end else begin
        nxt = inc24[5:0];
      end
    end
  end

  assign carry = inc && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= 6'h00;
    else if (wr_en) value <= wr_val;
    else if (inc)   value <= nxt;
  end

  a_r5_pm_flips_at_eleven: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && mode12 && value[4:0] == 5'h11)
      |=> (value[5] != $past(value[5])) && (value[4:0] == 5'h12));

  a_r4_day_wrap_24: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !mode12 && !wr_en) |=> (value == 6'h00));

  a_r4_range_24: assert property (@(posedge clk) disable iff (!rst_n)
    !mode12 |-> (value <= 6'h23));

endmodule

// File: rtl/rtc_date_field.sv
module rtc_date_field
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_val,
  input  logic       inc,
  input  logic [4:0] month,
  input  logic [7:0] year,
  output logic [5:0] value,
  output logic       carry
);

  logic [7:0] last_day;
  logic [7:0] bumped;
  logic       at_end;

  assign last_day = month_last_day({3'b000, month}, year);
  assign bumped   = bcd_inc({2'b00, value});
  assign at_end   = ({2'b00, value} == last_day);
  assign carry    = inc && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= 6'h01;
    else if (wr_en) value <= wr_val;
    else if (inc)   value <= at_end ? 6'h01 : bumped[5:0];
  end

  a_r6_date_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    value != 6'h00);

  a_r6_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !wr_en) |=> (value == 6'h01));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_fail,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RTC_A_CTRL);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(RTC_A_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(RTC_A_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(RTC_A_HOUR);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(RTC_A_DATE);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(RTC_A_WDAY);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(RTC_A_MON);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(RTC_A_YEAR);

  logic       mode12_q, stop_q, osc_flag_q;
  logic       time_wr, step;
  logic       we_sec, we_min, we_hour, we_date, we_wday, we_mon, we_year;
  logic [6:0] sec_v, min_v;
  logic [5:0] hour_v, date_v;
  logic [2:0] wday_v;
  logic [4:0] mon_v;
  logic [7:0] year_v;
  logic       c_sec, c_min, c_hour, c_date, c_mon, c_wday, c_year;

  assign we_sec  = reg_we && (reg_addr == A_SEC);
  assign we_min  = reg_we && (reg_addr == A_MIN);
  assign we_hour = reg_we && (reg_addr == A_HOUR);
  assign we_date = reg_we && (reg_addr == A_DATE);
  assign we_wday = reg_we && (reg_addr == A_WDAY);
  assign we_mon  = reg_we && (reg_addr == A_MON);
  assign we_year = reg_we && (reg_addr == A_YEAR);

  assign time_wr = we_sec | we_min | we_hour | we_date | we_wday | we_mon | we_year;
  assign step    = tick_1hz && !stop_q && !time_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (reg_we && reg_addr == A_CTRL) begin
      mode12_q <= reg_wdata[CTRL_BIT_MODE12];
      stop_q   <= reg_wdata[CTRL_BIT_STOP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        osc_flag_q <= 1'b1;
    else if (osc_fail) osc_flag_q <= 1'b1;
    else if (we_sec)   osc_flag_q <= reg_wdata[7];
  end

  rtc_bcd_field #(.W(7), .LO(8'h00), .HI(8'h59)) u_sec (
    .clk(clk), .rst_n(rst_n), .wr_en(we_sec), .wr_val(reg_wdata[6:0]),
    .inc(step), .value(sec_v), .carry(c_sec));

  rtc_bcd_field #(.W(7), .LO(8'h00), .HI(8'h59)) u_min (
    .clk(clk), .rst_n(rst_n), .wr_en(we_min), .wr_val(reg_wdata[6:0]),
    .inc(c_sec), .value(min_v), .carry(c_min));

  rtc_hour_field u_hour (
    .clk(clk), .rst_n(rst_n), .mode12(mode12_q), .wr_en(we_hour),
    .wr_val(reg_wdata[5:0]), .inc(c_min), .value(hour_v), .carry(c_hour));

  rtc_date_field u_date (
    .clk(clk), .rst_n(rst_n), .wr_en(we_date), .wr_val(reg_wdata[5:0]),
    .inc(c_hour), .month(mon_v), .year(year_v), .value(date_v), .carry(c_date));

  rtc_bcd_field #(.W(3), .LO(8'h00), .HI(8'h06)) u_wday (
    .clk(clk), .rst_n(rst_n), .wr_en(we_wday), .wr_val(reg_wdata[2:0]),
    .inc(c_hour), .value(wday_v), .carry(c_wday));

  rtc_bcd_field #(.W(5), .LO(8'h01), .HI(8'h12)) u_mon (
    .clk(clk), .rst_n(rst_n), .wr_en(we_mon), .wr_val(reg_wdata[4:0]),
    .inc(c_date), .value(mon_v), .carry(c_mon));

  rtc_bcd_field #(.W(8), .LO(8'h00), .HI(8'h99)) u_year (
    .clk(clk), .rst_n(rst_n), .wr_en(we_year), .wr_val(reg_wdata),
    .inc(c_mon), .value(year_v), .carry(c_year));

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_BIT_MODE12] = mode12_q;
        reg_rdata[CTRL_BIT_STOP]   = stop_q;
      end
      A_SEC:   reg_rdata = {osc_flag_q, sec_v};
      A_MIN:   reg_rdata = {1'b0, min_v};
      A_HOUR:  reg_rdata = {2'b00, hour_v};
      A_DATE:  reg_rdata = {2'b00, date_v};
      A_WDAY:  reg_rdata = {5'b00000, wday_v};
      A_MON:   reg_rdata = {3'b000, mon_v};
      A_YEAR:  reg_rdata = year_v;
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !time_wr) |=> $stable(sec_v) && $stable(min_v) && $stable(date_v));

  a_r10_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc_flag_q);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we_sec |=> (sec_v == $past(reg_wdata[6:0])));

  a_r11_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && we_min) |=> $stable(sec_v));

  a_r7_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wday && !we_wday) |=> (wday_v == 3'd0));

  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && !we_year) |=> (year_v == 8'h00) && (mon_v == 5'h01));

endmodule

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       osc_fail = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = 5'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_core #(.ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dt, input logic [7:0] wd,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr(5'd3, s); wr(5'd4, m); wr(5'd5, h); wr(5'd6, dt);
    wr(5'd7, wd); wr(5'd8, mo); wr(5'd9, yr);
  endtask

  task automatic t_reset();
    rd_check("R1 seconds+flag", 5'd3, 8'h80);
    rd_check("R1 minutes", 5'd4, 8'h00);
    rd_check("R1 hours", 5'd5, 8'h00);
    rd_check("R1 date", 5'd6, 8'h01);
    rd_check("R1 weekday", 5'd7, 8'h00);
    rd_check("R1 month", 5'd8, 8'h01);
    rd_check("R1 year", 5'd9, 8'h00);
    rd_check("R1 control", 5'd0, 8'h00);
  endtask

  task automatic t_map();
    wr(5'd1, 8'hFF);
    rd_check("R2 unused addr 1", 5'd1, 8'h00);
    rd_check("R2 unused addr 10", 5'd10, 8'h00);
    wr(5'd7, 8'hFD);
    rd_check("R2 weekday high bits", 5'd7, 8'h05);
    wr(5'd0, 8'hFF);
    rd_check("R2 control bits", 5'd0, 8'h28);
    wr(5'd0, 8'h00);
  endtask

  task automatic t_sec_min();
    set_time(8'h59, 8'h59, 8'h05, 8'h10, 8'h02, 8'h06, 8'h22);
    rd_check("R10 write clears flag", 5'd3, 8'h59);
    tick();
    rd_check("R3 seconds wrap", 5'd3, 8'h00);
    rd_check("R3 minutes wrap", 5'd4, 8'h00);
    rd_check("R4 hour step", 5'd5, 8'h06);
    tick();
    rd_check("R3 seconds count", 5'd3, 8'h01);
  endtask

  task automatic t_day_24h();
    set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h04, 8'h21);
    tick();
    rd_check("R4 hour 23 to 00", 5'd5, 8'h00);
    rd_check("R4 date advance", 5'd6, 8'h16);
    rd_check("R7 weekday 6 to 0", 5'd7, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h16, 8'h03, 8'h04, 8'h21);
    tick();
    rd_check("R7 weekday step", 5'd7, 8'h04);
  endtask

  task automatic t_12h();
    wr(5'd0, 8'h08);
    set_time(8'h59, 8'h59, 8'h11, 8'h05, 8'h01, 8'h03, 8'h20);
    tick();
    rd_check("R5 11AM to 12PM", 5'd5, 8'h32);
    rd_check("R5 no day at noon", 5'd6, 8'h05);
    set_time(8'h59, 8'h59, 8'h32, 8'h05, 8'h01, 8'h03, 8'h20);
    tick();
    rd_check("R5 12PM to 1PM", 5'd5, 8'h21);
    set_time(8'h59, 8'h59, 8'h31, 8'h05, 8'h01, 8'h03, 8'h20);
    tick();
    rd_check("R5 11PM to 12AM", 5'd5, 8'h12);
    rd_check("R5 day advance", 5'd6, 8'h06);
    wr(5'd0, 8'h00);
  endtask

  task automatic t_month_len();
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h00, 8'h04, 8'h23);
    tick();
    rd_check("R6 30-day date", 5'd6, 8'h01);
    rd_check("R6 30-day month", 5'd8, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h00, 8'h01, 8'h23);
    tick();
    rd_check("R6 jan 30 to 31", 5'd6, 8'h31);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h00, 8'h02, 8'h23);
    tick();
    rd_check("R6 feb non-leap date", 5'd6, 8'h01);
    rd_check("R6 feb non-leap month", 5'd8, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h00, 8'h02, 8'h24);
    tick();
    rd_check("R6 feb leap 29", 5'd6, 8'h29);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h00, 8'h02, 8'h00);
    tick();
    rd_check("R6 leap year 00 end", 5'd6, 8'h01);
    rd_check("R6 leap year 00 month", 5'd8, 8'h03);
  endtask

  task automatic t_year();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h12, 8'h99);
    tick();
    rd_check("R8 date", 5'd6, 8'h01);
    rd_check("R8 month 12 to 01", 5'd8, 8'h01);
    rd_check("R8 year 99 to 00", 5'd9, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h12, 8'h09);
    tick();
    rd_check("R8 year bcd carry", 5'd9, 8'h10);
  endtask

  task automatic t_stop();
    set_time(8'h40, 8'h10, 8'h10, 8'h10, 8'h01, 8'h05, 8'h30);
    wr(5'd0, 8'h20);
    tick();
    tick();
    rd_check("R9 stop holds seconds", 5'd3, 8'h40);
    wr(5'd0, 8'h00);
    tick();
    rd_check("R9 resume", 5'd3, 8'h41);
  endtask

  task automatic t_osc();
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    @(negedge clk);
    osc_fail = 1'b1;
    @(negedge clk);
    osc_fail = 1'b0;
    rd_check("R10 flag set by fail", 5'd3, 8'hA0);
    tick();
    rd_check("R10 counting with flag", 5'd3, 8'hA1);
    wr(5'd3, 8'h05);
    rd_check("R10 write clears", 5'd3, 8'h05);
  endtask

  task automatic t_collision();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd3; reg_wdata = 8'h30; tick_1hz = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick_1hz = 1'b0;
    rd_check("R11 write wins", 5'd3, 8'h30);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 8'h05; tick_1hz = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick_1hz = 1'b0;
    rd_check("R11 tick dropped", 5'd3, 8'h30);
    rd_check("R11 minute written", 5'd4, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_sec_min();
    t_day_24h();
    t_12h();
    t_month_len();
    t_year();
    t_stop();
    t_osc();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule